// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable element of a logic fabric. Its combinational path has three stages in a fixed order. The first stage is a K-input look-up table, which is a binary-select multiplexer tree over stored truth-table bits. The second stage is a one-bit full adder. The third stage is a rising-edge flip-flop. Three mode bits each bypass one stage, which gives seven useful mode combinations. The eighth combination, with all mode bits clear, is a plain wire from data input 0.

The cell is configured serially. While `cfgEn` is high, each clock edge shifts one bit from `cfgIn` into the configuration word. Bits enter LSB-first, and the oldest bit leaves on `cfgOut`, so several cells can form one longer chain. During configuration the cell outputs are held low and the flip-flop keeps its value. When configuration ends, the configuration word holds its value until the next load.

The adder takes its carry on `carryIn` and gives it on `carryOut`. Neighbouring cells therefore form a ripple-carry chain for multi-bit arithmetic.

Top module: `logic_cell`

## Requirements
- R1: While cfgEn is high, each rising edge shifts cfgIn into the top of a (2^K + 3)-bit word and shifts the word down. Once the load ends, bit 0 is shown on cfgOut. Bits [2^K-1:0] hold the truth table. Bit 2^K selects the LUT path (pickLut), bit 2^K+1 enables the adder (useAdd) and bit 2^K+2 enables the register (useReg). The word is unchanged while cfgEn is low.
- R2: With only pickLut set, cellOut equals truth-table bit number din (din read as an unsigned index). With table 0x8000 and K=4, the cell computes the AND of the four inputs.
- R3: With only useAdd set, cellOut is din[0] XOR addB XOR carryIn.
- R4: When useAdd is set, carryOut is the majority of the adder's first operand, addB and carryIn. When useAdd is clear, carryOut is 0.
- R5: With only useReg set, cellOut shows the value of din[0] captured at the previous rising edge.
- R6: The combined modes behave as the stages chained in order: LUT then register, adder then register, LUT then adder, and LUT then adder then register. When pickLut is set, the adder's first operand is the LUT output.
- R7: With all three mode bits clear, cellOut follows din[0] and carryOut is 0.
- R8: While cfgEn is high, cellOut and carryOut are 0 and the flip-flop keeps its value.
- R9: When rst is high at a rising edge, the flip-flop is cleared. The configuration word is unchanged.
- R10: Two cells with carryOut of one tied to carryIn of the next, both in adder-only mode, form a correct two-bit adder that includes the final carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high clear of the flip-flop |
| cfgEn | input | 1 | Configuration shift enable |
| cfgIn | input | 1 | Serial configuration data in |
| cfgOut | output | 1 | Serial configuration data out (bit 0 of the word) |
| din | input | LUT_K | LUT address inputs; din[0] is also the raw bypass input |
| addB | input | 1 | Second adder operand |
| carryIn | input | 1 | Carry into the adder |
| cellOut | output | 1 | Cell result |
| carryOut | output | 1 | Carry out of the adder |

## Verification
Configuration shifting and flip-flop capture share one clock edge, so an edge during a load must not disturb the stored bit. The bench captures a 1 in register mode, then reloads the cell while din is held at 0 over many edges. It then checks that cellOut still shows the 1 before the first normal edge, and that the outputs stayed low for the whole load. A second overlap is the registered adder modes, where carryOut stays combinational while the sum is registered. Both values are judged in the same sample after one edge.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  typedef struct packed {
    logic run;      // normal operation (not configuring)
    logic clear;    // flip-flop synchronous clear
    logic pickLut;  // first stage: LUT output instead of din[0]
    logic useAdd;   // second stage: adder sum instead of first stage
    logic useReg;   // third stage: flip-flop instead of combinational result
  } cellCtl_t;
endpackage

// File: rtl/lcell_ctrl.sv
module lcell_ctrl
  import lcell_pkg::*;
#(
  parameter int LUT_K = 4,
  localparam int LUT_BITS = 1 << LUT_K
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgEn,
  input  logic                cfgIn,
  output logic                cfgOut,
  output logic [LUT_BITS-1:0] lutMem,
  output cellCtl_t            ctl
);
  localparam int CFG_W    = LUT_BITS + 3;
  localparam int PICK_POS = LUT_BITS;
  localparam int ADD_POS  = LUT_BITS + 1;
  localparam int REG_POS  = LUT_BITS + 2;

  logic [CFG_W-1:0] cfgWord;

  // Serial load, LSB first: new bit enters at the top.
  always_ff @(posedge clk) begin
    if (cfgEn) cfgWord <= {cfgIn, cfgWord[CFG_W-1:1]};
  end

  assign cfgOut = cfgWord[0];
  assign lutMem = cfgWord[LUT_BITS-1:0];

  always_comb begin
    ctl.run     = !cfgEn;
    ctl.clear   = rst;
    ctl.pickLut = cfgWord[PICK_POS];
    ctl.useAdd  = cfgWord[ADD_POS];
    ctl.useReg  = cfgWord[REG_POS];
  end
endmodule

// File: rtl/lcell_dpath.sv
module lcell_dpath
  import lcell_pkg::*;
#(
  parameter int LUT_K = 4,
  localparam int LUT_BITS = 1 << LUT_K
) (
  input  logic                clk,
  input  cellCtl_t            ctl,
  input  logic [LUT_BITS-1:0] lutMem,
  input  logic [LUT_K-1:0]    din,
  input  logic                addB,
  input  logic                carryIn,
  output logic                cellOut,
  output logic                carryOut
);
  localparam int NODES = 2 * LUT_BITS - 1;

  // Heap-indexed mux tree: node 1 is the root, leaves sit at LUT_BITS..NODES.
  logic [NODES:1] node;
  logic lutOut, opA, sum, carry, comb, ffQ;

  for (genvar j = 0; j < LUT_BITS; j++) begin : g_leaf
    assign node[LUT_BITS + j] = lutMem[j];
  end

  for (genvar d = 0; d < LUT_K; d++) begin : g_level
    for (genvar n = (1 << d); n < (2 << d); n++) begin : g_node
      assign node[n] = din[LUT_K-1-d] ? node[2*n+1] : node[2*n];
    end
  end

  assign lutOut = node[1];

  // Stage 1 also provides the adder's first operand.
  assign opA   = ctl.pickLut ? lutOut : din[0];
  assign sum   = opA ^ addB ^ carryIn;
  assign carry = (opA & addB) | (carryIn & (opA ^ addB));
  assign comb  = ctl.useAdd ? sum : opA;

  always_ff @(posedge clk) begin
    if (ctl.clear)    ffQ <= 1'b0;
    else if (ctl.run) ffQ <= comb;
  end

  assign cellOut  = ctl.run & (ctl.useReg ? ffQ : comb);
  assign carryOut = ctl.run & ctl.useAdd & carry;
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lcell_pkg::*;
#(
  parameter int LUT_K = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgEn,
  input  logic             cfgIn,
  output logic             cfgOut,
  input  logic [LUT_K-1:0] din,
  input  logic             addB,
  input  logic             carryIn,
  output logic             cellOut,
  output logic             carryOut
);
  localparam int LUT_BITS = 1 << LUT_K;

  cellCtl_t            ctl;
  logic [LUT_BITS-1:0] lutMem;

  lcell_ctrl #(.LUT_K(LUT_K)) u_ctrl (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgIn(cfgIn),
    .cfgOut(cfgOut), .lutMem(lutMem), .ctl(ctl)
  );

  lcell_dpath #(.LUT_K(LUT_K)) u_dp (
    .clk(clk), .ctl(ctl), .lutMem(lutMem), .din(din),
    .addB(addB), .carryIn(carryIn), .cellOut(cellOut), .carryOut(carryOut)
  );
endmodule

// File: rtl/lcell_chk.sv
module lcell_chk
  import lcell_pkg::*;
#(
  parameter int LUT_K = 4,
  localparam int LUT_BITS = 1 << LUT_K
) (
  input logic                clk,
  input logic                rst,
  input logic                cfgEn,
  input logic                cfgIn,
  input logic                addB,
  input logic                carryIn,
  input logic                cellOut,
  input logic                carryOut,
  input logic [LUT_BITS-1:0] lutMem,
  input cellCtl_t            ctl
);
  // R1
  cfg_shift_chk: assert property (@(posedge clk) disable iff (rst)
    cfgEn |=> ctl.useReg == $past(cfgIn));

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfgEn |=> ($stable(lutMem) && $stable(ctl.pickLut) &&
                $stable(ctl.useAdd) && $stable(ctl.useReg)));

  // R8
  freeze_out_chk: assert property (@(posedge clk) disable iff (rst)
    cfgEn |-> (!cellOut && !carryOut));

  // R4
  carry_gen_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfgEn && ctl.useAdd && addB && carryIn) |-> carryOut);

  // R4
  carry_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfgEn && !ctl.useAdd) |-> !carryOut);

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && !cfgEn && ctl.useReg) |-> !cellOut);
endmodule

bind logic_cell lcell_chk #(.LUT_K(LUT_K)) u_chk (
  .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgIn(cfgIn), .addB(addB),
  .carryIn(carryIn), .cellOut(cellOut), .carryOut(carryOut),
  .lutMem(lutMem), .ctl(ctl)
);

// File: tb/tb_logic_cell.sv
module tb_logic_cell;
  localparam int K    = 4;
  localparam int CFGW = (1 << K) + 3;

  logic clk = 1'b0;
  logic rst = 1'b0, cfgEn = 1'b0, cfgIn = 1'b0;
  logic [K-1:0] din = '0, din2 = '0;
  logic addB = 1'b0, addB2 = 1'b0, carryIn = 1'b0;
  logic cfgMid, cfgOut2, cellOut, cellOut2, carryMid, carryOut2;

  int nChecks = 0, nFails = 0, sawOut = 0;

  always #10 clk = ~clk;  // 50 MHz

  logic_cell #(.LUT_K(K)) dut (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgIn(cfgIn), .cfgOut(cfgMid),
    .din(din), .addB(addB), .carryIn(carryIn), .cellOut(cellOut), .carryOut(carryMid)
  );

  logic_cell #(.LUT_K(K)) dut2 (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgIn(cfgMid), .cfgOut(cfgOut2),
    .din(din2), .addB(addB2), .carryIn(carryMid), .cellOut(cellOut2), .carryOut(carryOut2)
  );

  // {mode[2:0]={useReg,useAdd,pickLut}, din[3:0], addB, carryIn, expOut, expCarry}
  // LUT table is 16'h6996 (parity of din) for every entry.
  localparam logic [10:0] VEC [11] = '{
    11'b001_0111_0_0_1_0,
    11'b001_1111_0_0_0_0,
    11'b010_0001_1_0_0_1,
    11'b010_0000_1_1_0_1,
    11'b010_0001_0_0_1_0,
    11'b100_0001_0_0_1_0,
    11'b101_1011_0_0_1_0,
    11'b110_0001_1_1_1_1,
    11'b011_0010_1_0_0_1,
    11'b111_1110_0_1_0_1,
    11'b000_0001_1_1_1_0
  };

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic shiftBits(input logic [2*CFGW-1:0] bits, input int n);
    @(negedge clk);
    cfgEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      cfgIn = bits[i];
      #5;
      if (cellOut !== 1'b0 || carryMid !== 1'b0) sawOut++;
      @(negedge clk);
    end
    cfgEn = 1'b0;
  endtask

  task automatic loadCfg(input logic [2:0] mode, input logic [15:0] lut);
    shiftBits({{CFGW{1'b0}}, mode, lut}, CFGW);
  endtask

  function automatic string modeTag(input logic [2:0] m);
    case (m)
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b100:  return "R5";
      3'b000:  return "R7";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #4_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // Reset state: capture a 1 in register mode, then reset (R9)
    loadCfg(3'b100, 16'h0000);
    din = 4'b0001;
    @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; din = 4'b0000;
    #5 chk("R9 reset clears flip-flop", cellOut, 1'b0);
    // Config survives reset: register mode still active
    din = 4'b0001;
    @(posedge clk); #5;
    chk("R9 config kept through reset", cellOut, 1'b1);

    // Serial load layout and cfgOut (R1), AND-of-inputs table (R2)
    loadCfg(3'b001, 16'h8001);
    #5 chk("R1 cfgOut shows bit 0", cfgMid, 1'b1);
    din = 4'b1111; #1 chk("R2 AND all ones", cellOut, 1'b1);
    din = 4'b0111; #1 chk("R2 AND one zero", cellOut, 1'b0);
    din = 4'b0000; #1 chk("R1 LSB table bit at index 0", cellOut, 1'b1);
    loadCfg(3'b001, 16'h8000);
    #5 chk("R1 cfgOut shows bit 0 clear", cfgMid, 1'b0);

    // Table walk over all modes
    foreach (VEC[i]) begin
      logic [2:0] m;
      m = VEC[i][10:8];
      loadCfg(m, 16'h6996);
      din = VEC[i][7:4]; addB = VEC[i][3]; carryIn = VEC[i][2];
      if (m[2]) @(posedge clk);
      #5;
      chk(modeTag(m), cellOut, VEC[i][1]);
      chk("R4 carry", carryMid, VEC[i][0]);
    end
    addB = 1'b0; carryIn = 1'b0;

    // Freeze during configuration (R8)
    loadCfg(3'b100, 16'h0000);
    din = 4'b0001;
    @(posedge clk); #5;
    chk("R8 setup capture", cellOut, 1'b1);
    din = 4'b0000;
    sawOut = 0;
    loadCfg(3'b100, 16'h0000);
    chk("R8 outputs low during load", (sawOut == 0), 1'b1);
    #5 chk("R8 flip-flop held over load edges", cellOut, 1'b1);

    // Two-cell carry chain (R10): dut2 word shifted first
    shiftBits({3'b010, 16'h0000, 3'b010, 16'h0000}, 2*CFGW);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++) begin
          logic [2:0] s;
          s = 3'(a) + 3'(b) + 3'(c);
          din[0] = a[0]; din2[0] = a[1];
          addB = b[0]; addB2 = b[1]; carryIn = c[0];
          #5;
          chk("R10 sum bit 0", cellOut, s[0]);
          chk("R10 sum bit 1", cellOut2, s[1]);
          chk("R10 final carry", carryOut2, s[2]);
          @(negedge clk);
        end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule